// File: doc/BRIEF.md
# Far Control Transfer Privilege Checker

This block rules on a far JMP or CALL that wants to load a new code segment. It gets the caller's current privilege level and the requested privilege level from the selector. It also gets a description of the descriptor the selector names: its kind, its privilege level, its conforming bit and its present bit. When that descriptor is a call gate, it further gets the attributes of the code segment the gate points to. One clock after a request it returns one verdict: allow, protection fault or not-present fault. The verdict also carries the privilege level that would be in force after the transfer and a flag saying the stack must be swapped.

Three paths carry different rules. A direct jump to a nonconforming code segment must stay at the same level. A direct jump to a conforming segment may reach a more privileged segment, but it keeps the caller's level. A transfer through a call gate is checked against a privilege window. It is the only way to move to a numerically lower level, and only a CALL may do that.

Encodings: descriptor kind 0 = data, 1 = code, 2 = call gate, 3 = other system descriptor. Fault code 0 = none, 1 = protection, 2 = not present.

Top module: `ctl_xfer_check`

## Requirements
- R1: After reset, and in any cycle whose previous cycle had no request, valid_o, allow_o and stack_switch_o are 0 and fault_o and new_cpl_o are 0.
- R2: A request sampled at a clock edge produces its verdict on valid_o, allow_o, fault_o, new_cpl_o and stack_switch_o after that edge, valid for exactly one cycle.
- R3: A direct transfer to a nonconforming code segment (kind 1, conforming bit 0) is allowed only when the segment privilege equals the current privilege. Otherwise the fault code is 1.
- R4: A direct transfer to a conforming code segment is allowed only when the segment privilege is numerically less than or equal to the current privilege. Otherwise the fault code is 1.
- R5: Any allowed direct transfer leaves new_cpl_o equal to the current privilege and stack_switch_o at 0.
- R6: A target of kind 0 or 3 always gives fault code 1.
- R7: A direct code target that passes its privilege rule but is marked not present gives fault code 2. If it fails its privilege rule, fault code 1 is reported.
- R8: A gate transfer gives fault code 1 unless destination privilege ≤ max(RPL, CPL) ≤ gate privilege.
- R9: A gate that passes the window but is not present gives fault code 2. After that, a destination that is not code, or whose privilege is numerically above the current one, gives fault code 1. Last, a destination that is not present gives fault code 2.
- R10: A gate CALL to a nonconforming destination with a numerically lower privilege is allowed. new_cpl_o is then the destination privilege and stack_switch_o is 1.
- R11: A gate JMP to a nonconforming destination with a numerically lower privilege gives fault code 1. A gate JMP at the same level is allowed with no stack switch.
- R12: A gate transfer to a conforming destination keeps the current privilege and never asks for a stack switch.
- R13: On any fault, new_cpl_o equals the current privilege and stack_switch_o is 0. allow_o is 1 exactly when the fault code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request present this cycle |
| is_call_i | input | 1 | 1 = CALL, 0 = JMP |
| cpl_i | input | PL_W | Current privilege level |
| rpl_i | input | PL_W | Requested privilege level from the selector |
| desc_kind_i | input | 2 | Kind of the named descriptor |
| desc_dpl_i | input | PL_W | Privilege of the named descriptor (gate privilege for a gate) |
| desc_conf_i | input | 1 | Conforming bit of a code descriptor |
| desc_present_i | input | 1 | Present bit of the named descriptor |
| dest_code_i | input | 1 | Gate destination is a code segment |
| dest_dpl_i | input | PL_W | Gate destination privilege |
| dest_conf_i | input | 1 | Gate destination conforming bit |
| dest_present_i | input | 1 | Gate destination present bit |
| valid_o | output | 1 | Verdict valid |
| allow_o | output | 1 | Transfer permitted |
| fault_o | output | 2 | Fault code |
| new_cpl_o | output | PL_W | Privilege level after the transfer |
| stack_switch_o | output | 1 | Privilege change needs a new stack |

## Verification
The assertions check several rules on every cycle. Outputs stay quiet when no verdict is due. allow_o agrees with the fault code. A stack switch happens only on an allowed CALL that lowers the level numerically. Direct transfers never change the level. Any allowed gate result lies inside the privilege window. Other behaviour can only be shown by the bench's scenarios: the exact fault code for each failing combination, the order in which protection and not-present faults are ranked, and the level reported for conforming and same-level destinations.

// File: rtl/xfer_chk_pkg.sv
package xfer_chk_pkg;
  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_CODE = 2'd1,
    KIND_GATE = 2'd2,
    KIND_SYS  = 2'd3
  } desc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PROT = 2'd1,
    FLT_NP   = 2'd2
  } fault_e;
endpackage

// File: rtl/xfer_direct_chk.sv
module xfer_direct_chk
  import xfer_chk_pkg::*;
#(
  parameter int unsigned PL_W = 2
) (
  input  desc_kind_e      kind_i,
  input  logic [PL_W-1:0] cpl_i,
  input  logic [PL_W-1:0] dpl_i,
  input  logic            conf_i,
  input  logic            present_i,
  output fault_e          fault_o,
  output logic [PL_W-1:0] new_cpl_o
);
  logic priv_ok;

  // conforming: may reach inward; nonconforming: same level only
  assign priv_ok = conf_i ? (dpl_i <= cpl_i) : (dpl_i == cpl_i);

  always_comb begin
    if (kind_i != KIND_CODE)  fault_o = FLT_PROT;
    else if (!priv_ok)        fault_o = FLT_PROT;
    else if (!present_i)      fault_o = FLT_NP;
    else                      fault_o = FLT_NONE;
  end

  assign new_cpl_o = cpl_i;
endmodule

// File: rtl/xfer_gate_chk.sv
module xfer_gate_chk
  import xfer_chk_pkg::*;
#(
  parameter int unsigned PL_W = 2
) (
  input  logic            is_call_i,
  input  logic [PL_W-1:0] cpl_i,
  input  logic [PL_W-1:0] rpl_i,
  input  logic [PL_W-1:0] gate_dpl_i,
  input  logic            gate_present_i,
  input  logic            dest_code_i,
  input  logic [PL_W-1:0] dest_dpl_i,
  input  logic            dest_conf_i,
  input  logic            dest_present_i,
  output fault_e          fault_o,
  output logic [PL_W-1:0] new_cpl_o,
  output logic            stack_switch_o
);
  logic [PL_W-1:0] eff_pl;
  logic            inward;

  assign eff_pl = (rpl_i > cpl_i) ? rpl_i : cpl_i;
  assign inward = !dest_conf_i && (dest_dpl_i < cpl_i);

  always_comb begin
    fault_o        = FLT_NONE;
    new_cpl_o      = cpl_i;
    stack_switch_o = 1'b0;
    if ((dest_dpl_i > eff_pl) || (eff_pl > gate_dpl_i)) fault_o = FLT_PROT;
    else if (!gate_present_i)                           fault_o = FLT_NP;
    else if (!dest_code_i)                              fault_o = FLT_PROT;
    else if (dest_dpl_i > cpl_i)                        fault_o = FLT_PROT;
    else if (inward && !is_call_i)                      fault_o = FLT_PROT;
    else if (!dest_present_i)                           fault_o = FLT_NP;
    else begin
      new_cpl_o      = inward ? dest_dpl_i : cpl_i;
      stack_switch_o = inward;
    end
  end
endmodule

// File: rtl/ctl_xfer_check.sv
module ctl_xfer_check
  import xfer_chk_pkg::*;
#(
  parameter int unsigned PL_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            is_call_i,
  input  logic [PL_W-1:0] cpl_i,
  input  logic [PL_W-1:0] rpl_i,
  input  logic [1:0]      desc_kind_i,
  input  logic [PL_W-1:0] desc_dpl_i,
  input  logic            desc_conf_i,
  input  logic            desc_present_i,
  input  logic            dest_code_i,
  input  logic [PL_W-1:0] dest_dpl_i,
  input  logic            dest_conf_i,
  input  logic            dest_present_i,
  output logic            valid_o,
  output logic            allow_o,
  output logic [1:0]      fault_o,
  output logic [PL_W-1:0] new_cpl_o,
  output logic            stack_switch_o
);
  desc_kind_e      kind;
  fault_e          dir_fault, gate_fault, sel_fault;
  logic [PL_W-1:0] dir_cpl, gate_cpl, sel_cpl;
  logic            gate_sw, sel_sw, is_gate;

  assign kind    = desc_kind_e'(desc_kind_i);
  assign is_gate = (kind == KIND_GATE);

  xfer_direct_chk #(.PL_W(PL_W)) u_direct (
    .kind_i    (kind),
    .cpl_i     (cpl_i),
    .dpl_i     (desc_dpl_i),
    .conf_i    (desc_conf_i),
    .present_i (desc_present_i),
    .fault_o   (dir_fault),
    .new_cpl_o (dir_cpl)
  );

  xfer_gate_chk #(.PL_W(PL_W)) u_gate (
    .is_call_i      (is_call_i),
    .cpl_i          (cpl_i),
    .rpl_i          (rpl_i),
    .gate_dpl_i     (desc_dpl_i),
    .gate_present_i (desc_present_i),
    .dest_code_i    (dest_code_i),
    .dest_dpl_i     (dest_dpl_i),
    .dest_conf_i    (dest_conf_i),
    .dest_present_i (dest_present_i),
    .fault_o        (gate_fault),
    .new_cpl_o      (gate_cpl),
    .stack_switch_o (gate_sw)
  );

  assign sel_fault = is_gate ? gate_fault : dir_fault;
  assign sel_cpl   = is_gate ? gate_cpl   : dir_cpl;
  assign sel_sw    = is_gate && gate_sw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o        <= 1'b0;
      allow_o        <= 1'b0;
      fault_o        <= 2'd0;
      new_cpl_o      <= '0;
      stack_switch_o <= 1'b0;
    end else if (req_valid_i) begin
      valid_o        <= 1'b1;
      allow_o        <= (sel_fault == FLT_NONE);
      fault_o        <= sel_fault;
      new_cpl_o      <= sel_cpl;
      stack_switch_o <= sel_sw;
    end else begin
      valid_o        <= 1'b0;
      allow_o        <= 1'b0;
      fault_o        <= 2'd0;
      new_cpl_o      <= '0;
      stack_switch_o <= 1'b0;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!allow_o && fault_o == 2'd0 && !stack_switch_o && new_cpl_o == '0));

  // R2
  verdict_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o);

  // R13
  allow_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (allow_o == (fault_o == 2'd0)));

  // R13
  fault_keeps_cpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !allow_o) |-> (new_cpl_o == $past(cpl_i) && !stack_switch_o));

  // R5
  direct_same_cpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && allow_o && $past(desc_kind_i) != 2'd2)
      |-> (new_cpl_o == $past(cpl_i) && !stack_switch_o));

  // R10
  stack_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && stack_switch_o)
      |-> (allow_o && $past(is_call_i) && new_cpl_o < $past(cpl_i)));

  // R8
  gate_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && allow_o && $past(desc_kind_i) == 2'd2)
      |-> ($past(dest_dpl_i) <= new_cpl_o && $past(rpl_i) <= $past(desc_dpl_i)
           && $past(cpl_i) <= $past(desc_dpl_i)));

  // R11
  jmp_no_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(is_call_i)) |-> !stack_switch_o);
endmodule

// File: tb/ctl_xfer_check_bench.sv
module ctl_xfer_check_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, is_call = 1'b0;
  logic [1:0] cpl = '0, rpl = '0, kind = '0, dpl = '0, dest_dpl = '0;
  logic       conf = 1'b0, pres = 1'b0, dest_code = 1'b0, dest_conf = 1'b0, dest_pres = 1'b0;
  logic       valid_o, allow_o, stack_switch_o;
  logic [1:0] fault_o, new_cpl_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_xfer_check u_ctl_xfer_check (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .is_call_i(is_call),
    .cpl_i(cpl), .rpl_i(rpl), .desc_kind_i(kind), .desc_dpl_i(dpl),
    .desc_conf_i(conf), .desc_present_i(pres), .dest_code_i(dest_code),
    .dest_dpl_i(dest_dpl), .dest_conf_i(dest_conf), .dest_present_i(dest_pres),
    .valid_o(valid_o), .allow_o(allow_o), .fault_o(fault_o),
    .new_cpl_o(new_cpl_o), .stack_switch_o(stack_switch_o)
  );

  task automatic expect_out(string rq, logic ev, logic ea, logic [1:0] ef,
                            logic [1:0] ec, logic es);
    n_chk++;
    if ({valid_o, allow_o, fault_o, new_cpl_o, stack_switch_o} !== {ev, ea, ef, ec, es}) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b allow=%0b fault=%0d cpl=%0d sw=%0b, expected valid=%0b allow=%0b fault=%0d cpl=%0d sw=%0b",
               rq, valid_o, allow_o, fault_o, new_cpl_o, stack_switch_o, ev, ea, ef, ec, es);
    end
  endtask

  task automatic fire();
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic direct(string rq, logic [1:0] c, logic [1:0] k, logic [1:0] d,
                        logic cf, logic p, logic ea, logic [1:0] ef, logic [1:0] ec);
    @(negedge clk);
    is_call = 1'b0; cpl = c; rpl = c; kind = k; dpl = d; conf = cf; pres = p;
    dest_code = 1'b0; dest_dpl = 2'd3; dest_conf = 1'b0; dest_pres = 1'b0;
    fire();
    expect_out(rq, 1'b1, ea, ef, ec, 1'b0);
  endtask

  task automatic gate(string rq, logic call, logic [1:0] c, logic [1:0] r, logic [1:0] g,
                      logic gp, logic dc, logic [1:0] dd, logic dcf, logic dp,
                      logic ea, logic [1:0] ef, logic [1:0] ec, logic es);
    @(negedge clk);
    is_call = call; cpl = c; rpl = r; kind = 2'd2; dpl = g; conf = 1'b0; pres = gp;
    dest_code = dc; dest_dpl = dd; dest_conf = dcf; dest_pres = dp;
    fire();
    expect_out(rq, 1'b1, ea, ef, ec, es);
  endtask

  task automatic test_reset_idle();
    @(negedge clk);
    expect_out("R1 reset", 1'b0, 1'b0, 2'd0, 2'd0, 1'b0);
    direct("R2 request", 2'd1, 2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 2'd0, 2'd1);
    @(negedge clk);
    expect_out("R2 single cycle / R1 idle", 1'b0, 1'b0, 2'd0, 2'd0, 1'b0);
  endtask

  task automatic test_direct();
    direct("R3 nonconf same", 2'd2, 2'd1, 2'd2, 1'b0, 1'b1, 1'b1, 2'd0, 2'd2);
    direct("R3 nonconf inward", 2'd2, 2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 2'd1, 2'd2);
    direct("R3 nonconf outward", 2'd2, 2'd1, 2'd3, 1'b0, 1'b1, 1'b0, 2'd1, 2'd2);
    direct("R4 R5 conf inward", 2'd3, 2'd1, 2'd0, 1'b1, 1'b1, 1'b1, 2'd0, 2'd3);
    direct("R4 conf same", 2'd2, 2'd1, 2'd2, 1'b1, 1'b1, 1'b1, 2'd0, 2'd2);
    direct("R4 conf outward", 2'd1, 2'd1, 2'd2, 1'b1, 1'b1, 1'b0, 2'd1, 2'd1);
    direct("R6 data target", 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd1, 2'd0);
    direct("R6 system target", 2'd0, 2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 2'd1, 2'd0);
    direct("R7 not present", 2'd1, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd1);
    direct("R7 priv before present", 2'd1, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd1);
  endtask

  task automatic test_gate_window();
    gate("R8 R10 call inward", 1'b1, 2'd2, 2'd0, 2'd3, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1,
         1'b1, 2'd0, 2'd0, 1'b1);
    gate("R8 edge eff==gate", 1'b1, 2'd2, 2'd2, 2'd2, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1,
         1'b1, 2'd0, 2'd0, 1'b1);
    gate("R8 gate too privileged", 1'b1, 2'd2, 2'd0, 2'd1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1,
         1'b0, 2'd1, 2'd2, 1'b0);
    gate("R8 rpl above gate", 1'b1, 2'd2, 2'd3, 2'd2, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1,
         1'b0, 2'd1, 2'd2, 1'b0);
  endtask

  task automatic test_gate_kinds();
    gate("R11 jmp inward", 1'b0, 2'd2, 2'd0, 2'd3, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1,
         1'b0, 2'd1, 2'd2, 1'b0);
    gate("R11 jmp same level", 1'b0, 2'd2, 2'd2, 2'd3, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1,
         1'b1, 2'd0, 2'd2, 1'b0);
    gate("R12 conforming dest", 1'b1, 2'd3, 2'd3, 2'd3, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1,
         1'b1, 2'd0, 2'd3, 1'b0);
    gate("R9 gate not present", 1'b1, 2'd2, 2'd0, 2'd3, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1,
         1'b0, 2'd2, 2'd2, 1'b0);
    gate("R9 window before gate present", 1'b1, 2'd2, 2'd0, 2'd1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1,
         1'b0, 2'd1, 2'd2, 1'b0);
    gate("R9 dest not code", 1'b1, 2'd2, 2'd0, 2'd3, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1,
         1'b0, 2'd1, 2'd2, 1'b0);
    gate("R9 dest not present", 1'b1, 2'd2, 2'd0, 2'd3, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0,
         1'b0, 2'd2, 2'd2, 1'b0);
    gate("R9 dest outward", 1'b1, 2'd1, 2'd3, 2'd3, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1,
         1'b0, 2'd1, 2'd1, 1'b0);
    gate("R13 fault keeps cpl", 1'b0, 2'd3, 2'd3, 2'd3, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1,
         1'b0, 2'd1, 2'd3, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset_idle();
    test_direct();
    test_gate_window();
    test_gate_kinds();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule